// File: doc/BRIEF.md
# Monotonic Memory Protection Guard

This block holds the protection settings for a 64 KB code flash and a 256-byte data EEPROM. It judges every program or erase request against those settings before the request reaches the array. A flash address can be covered by two windows. The top window ends at the last address and reaches downward. The base window starts at a fixed anchor and reaches upward. A single closing bit covers the whole flash at once. The EEPROM is covered from its highest byte downward, in steps of 32 bytes.

Configuration writes pass through a filter that only lets protection grow. The filter treats each field of a written byte on its own. A field that would weaken protection keeps its old value. The other fields of the same write still take effect. Only reset restores the open configuration. A request that touches any protected byte is refused. The refusal shows as a one-cycle blocked pulse and sets a sticky violation flag. A permitted request shows as a one-cycle ok pulse.

Top module: `nvm_prot_guard`

## Requirements
- R1: After reset, the flash setting reads 0xC8 and the EEPROM setting reads 0x80. No address is protected and the violation flag is 0.
- R2: The flash setting uses these fields: [7] open, [6] top disable, [5:4] top size, [3] base disable, [2] always 0, [1:0] base size. With open=1 and top disable=0, addresses at or above 0x10000 − 2048·2^size are protected.
- R3: With open=1 and base disable=0, addresses from 0x8000 up to 0x8000 + 1024·2^size − 1 are protected. Addresses below 0x8000 stay unprotected.
- R4: With open=0, every flash address is protected.
- R5: The EEPROM setting uses these fields: [7] enable (1 means unprotected), [6:3] always 0, [2:0] size. With enable=0, EEPROM offsets at or above 256 − 32·(size+1) are protected.
- R6: The open bit and both disable bits can only change from 1 to 0. The size of an enabled flash window changes only to a larger value. The size of a disabled window accepts any value.
- R7: The EEPROM enable bit can only change from 1 to 0. The EEPROM size changes only to a larger value.
- R8: A write that breaks the rules for some fields keeps those fields unchanged and still applies its legal fields.
- R9: The request kind is encoded as 0 = program one byte, 1 = sector erase (512-byte aligned for flash, 2-byte aligned for EEPROM), and 2 or 3 = whole-array erase. A request is blocked if any byte in its span is protected.
- R10: A request gets a result one cycle later: exactly one of ok or blocked pulses. Blocked sets the violation flag. The flag clears on viol_clr, but a new block in the same cycle wins over the clear.
- R11: A configuration write is readable, and takes effect, from the next cycle. A request in the same cycle as a write is judged against the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = flash setting, 1 = EEPROM setting |
| cfg_wdata | input | 8 | Written value |
| flash_cfg | output | 8 | Current flash setting |
| ee_cfg | output | 8 | Current EEPROM setting |
| req_valid | input | 1 | Request strobe |
| req_ee | input | 1 | 0 = flash target, 1 = EEPROM target |
| req_kind | input | 2 | Request kind (see R9) |
| req_addr | input | 16 | Target address (EEPROM uses bits 7:0) |
| viol_clr | input | 1 | Clear the violation flag |
| req_ok | output | 1 | Request permitted (one-cycle pulse) |
| req_blocked | output | 1 | Request refused (one-cycle pulse) |
| viol_flag | output | 1 | Sticky protection-violation flag |

## Verification
Every result lands one clock edge after its stimulus. A configuration write is visible at the next edge, and so are the request verdict pulses and the flag. The bench drives inputs on a falling edge. It samples on the next falling edge, which is half a cycle after the single register stage has updated. The same-cycle write-and-request case relies on that one-edge lag: the verdict must come from the setting held before the write.

// File: rtl/nvm_prot_pkg.sv
package nvm_prot_pkg;

  typedef struct packed {
    logic       open;
    logic       hi_dis;
    logic [1:0] hi_sz;
    logic       lo_dis;
    logic       rsvd;
    logic [1:0] lo_sz;
  } fcfg_t;

  typedef struct packed {
    logic       en;
    logic [3:0] rsvd;
    logic [2:0] sz;
  } ecfg_t;

  typedef enum logic [1:0] {
    K_PROG = 2'd0,
    K_SECT = 2'd1,
    K_BLK  = 2'd2,
    K_BLKX = 2'd3
  } kind_t;

  localparam fcfg_t FCFG_RST = '{open: 1'b1, hi_dis: 1'b1, hi_sz: 2'd0,
                                 lo_dis: 1'b1, rsvd: 1'b0, lo_sz: 2'd0};
  localparam ecfg_t ECFG_RST = '{en: 1'b1, rsvd: 4'd0, sz: 3'd0};

  // Grow-only merge of a flash setting write, field by field
  function automatic fcfg_t merge_flash(input fcfg_t cur, input fcfg_t wr);
    fcfg_t r;
    r        = cur;
    r.rsvd   = 1'b0;
    r.open   = cur.open & wr.open;
    r.hi_dis = cur.hi_dis & wr.hi_dis;
    r.lo_dis = cur.lo_dis & wr.lo_dis;
    if (cur.hi_dis || (wr.hi_sz > cur.hi_sz)) r.hi_sz = wr.hi_sz;
    if (cur.lo_dis || (wr.lo_sz > cur.lo_sz)) r.lo_sz = wr.lo_sz;
    return r;
  endfunction

  // Grow-only merge of an EEPROM setting write
  function automatic ecfg_t merge_ee(input ecfg_t cur, input ecfg_t wr);
    ecfg_t r;
    r      = cur;
    r.rsvd = 4'd0;
    r.en   = cur.en & wr.en;
    if (wr.sz > cur.sz) r.sz = wr.sz;
    return r;
  endfunction

endpackage

// File: rtl/nvm_prot_regs.sv
module nvm_prot_regs
  import nvm_prot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_sel,
  input  logic [7:0] cfg_wdata,
  output fcfg_t      fcfg,
  output ecfg_t      ecfg
);

  logic f_wr_fire;
  logic e_wr_fire;

  assign f_wr_fire = cfg_we && !cfg_sel;
  assign e_wr_fire = cfg_we &&  cfg_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcfg <= FCFG_RST;
      ecfg <= ECFG_RST;
    end else begin
      if (f_wr_fire) fcfg <= merge_flash(fcfg, fcfg_t'(cfg_wdata));
      if (e_wr_fire) ecfg <= merge_ee(ecfg, ecfg_t'(cfg_wdata));
    end
  end

  AST_OPEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !fcfg.open |=> !fcfg.open);                                        // R6
  AST_HI_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !fcfg.hi_dis |=> !fcfg.hi_dis);                                    // R6
  AST_HI_SZ_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    !fcfg.hi_dis |=> fcfg.hi_sz >= $past(fcfg.hi_sz));                 // R6
  AST_LO_SZ_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    !fcfg.lo_dis |=> fcfg.lo_sz >= $past(fcfg.lo_sz));                 // R6
  AST_EE_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !ecfg.en |=> !ecfg.en);                                            // R7
  AST_EE_SZ_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    ecfg.sz >= $past(ecfg.sz));                                        // R7
  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(fcfg) && $stable(ecfg)));                     // R11

endmodule

// File: rtl/nvm_prot_check.sv
module nvm_prot_check
  import nvm_prot_pkg::*;
#(
  parameter int AW         = 16,
  parameter int EE_AW      = 8,
  parameter int LOW_ANCHOR = 'h8000,
  parameter int HI_UNIT    = 2048,
  parameter int LO_UNIT    = 1024,
  parameter int EE_UNIT    = 32,
  parameter int FSEC_LG    = 9,
  parameter int ESEC_LG    = 1
) (
  input  logic          f_open,
  input  logic          f_hi_dis,
  input  logic [1:0]    f_hi_sz,
  input  logic          f_lo_dis,
  input  logic [1:0]    f_lo_sz,
  input  logic          e_en,
  input  logic [2:0]    e_sz,
  input  logic          req_ee,
  input  kind_t         req_kind,
  input  logic [AW-1:0] req_addr,
  output logic          flash_hit,
  output logic          ee_hit,
  output logic          hit
);

  localparam int W = AW + 2;
  typedef logic [W-1:0] wa_t;

  localparam wa_t ONE    = wa_t'(1);
  localparam wa_t F_LAST = (ONE << AW) - ONE;
  localparam wa_t E_LAST = (ONE << EE_AW) - ONE;

  function automatic wa_t span_first(input wa_t a, input int lg, input kind_t k);
    case (k)
      K_PROG:  return a;
      K_SECT:  return (a >> lg) << lg;
      default: return '0;
    endcase
  endfunction

  function automatic wa_t span_last(input wa_t a, input int lg, input wa_t last,
                                    input kind_t k);
    case (k)
      K_PROG:  return a;
      K_SECT:  return span_first(a, lg, k) + ((ONE << lg) - ONE);
      default: return last;
    endcase
  endfunction

  function automatic logic overlaps(input wa_t a0, input wa_t a1,
                                    input wa_t b0, input wa_t b1);
    return (a0 <= b1) && (a1 >= b0);
  endfunction

  wa_t fa, ea;
  wa_t f_first, f_last, e_first, e_last;
  wa_t hi_base, lo_end, ee_base;
  logic hi_hit, lo_hit;

  always_comb begin
    fa      = wa_t'(req_addr);
    ea      = wa_t'(req_addr[EE_AW-1:0]);
    f_first = span_first(fa, FSEC_LG, req_kind);
    f_last  = span_last(fa, FSEC_LG, F_LAST, req_kind);
    e_first = span_first(ea, ESEC_LG, req_kind);
    e_last  = span_last(ea, ESEC_LG, E_LAST, req_kind);
    hi_base = (ONE << AW) - (wa_t'(HI_UNIT) << f_hi_sz);
    lo_end  = wa_t'(LOW_ANCHOR) + (wa_t'(LO_UNIT) << f_lo_sz) - ONE;
    ee_base = (ONE << EE_AW) - wa_t'(EE_UNIT) * (wa_t'(e_sz) + ONE);
  end

  assign hi_hit    = !f_hi_dis && overlaps(f_first, f_last, hi_base, F_LAST);
  assign lo_hit    = !f_lo_dis && overlaps(f_first, f_last, wa_t'(LOW_ANCHOR), lo_end);
  assign flash_hit = !f_open || hi_hit || lo_hit;
  assign ee_hit    = !e_en && overlaps(e_first, e_last, ee_base, E_LAST);
  assign hit       = req_ee ? ee_hit : flash_hit;

endmodule

// File: rtl/nvm_prot_guard.sv
module nvm_prot_guard
  import nvm_prot_pkg::*;
#(
  parameter int AW         = 16,
  parameter int EE_AW      = 8,
  parameter int LOW_ANCHOR = 'h8000,
  parameter int HI_UNIT    = 2048,
  parameter int LO_UNIT    = 1024,
  parameter int EE_UNIT    = 32,
  parameter int FSEC_LG    = 9,
  parameter int ESEC_LG    = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    flash_cfg,
  output logic [7:0]    ee_cfg,
  input  logic          req_valid,
  input  logic          req_ee,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic          viol_clr,
  output logic          req_ok,
  output logic          req_blocked,
  output logic          viol_flag
);

  fcfg_t fcfg;
  ecfg_t ecfg;
  logic  flash_hit, ee_hit, req_hit;

  nvm_prot_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .fcfg      (fcfg),
    .ecfg      (ecfg)
  );

  nvm_prot_check #(
    .AW(AW), .EE_AW(EE_AW), .LOW_ANCHOR(LOW_ANCHOR), .HI_UNIT(HI_UNIT),
    .LO_UNIT(LO_UNIT), .EE_UNIT(EE_UNIT), .FSEC_LG(FSEC_LG), .ESEC_LG(ESEC_LG)
  ) u_check (
    .f_open    (fcfg.open),
    .f_hi_dis  (fcfg.hi_dis),
    .f_hi_sz   (fcfg.hi_sz),
    .f_lo_dis  (fcfg.lo_dis),
    .f_lo_sz   (fcfg.lo_sz),
    .e_en      (ecfg.en),
    .e_sz      (ecfg.sz),
    .req_ee    (req_ee),
    .req_kind  (kind_t'(req_kind)),
    .req_addr  (req_addr),
    .flash_hit (flash_hit),
    .ee_hit    (ee_hit),
    .hit       (req_hit)
  );

  assign flash_cfg = fcfg;
  assign ee_cfg    = ecfg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_ok      <= 1'b0;
      req_blocked <= 1'b0;
      viol_flag   <= 1'b0;
    end else begin
      req_ok      <= req_valid && !req_hit;
      req_blocked <= req_valid &&  req_hit;
      if (req_valid && req_hit) viol_flag <= 1'b1;
      else if (viol_clr)        viol_flag <= 1'b0;
    end
  end

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ok && req_blocked));                                         // R10
  AST_VERDICT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (req_ok || req_blocked));                            // R10
  AST_FLAG_ON_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    req_blocked |-> viol_flag);                                        // R10
  AST_CLOSED_BLOCKS_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ee && !flash_cfg[7]) |=> req_blocked);          // R4

endmodule

// File: tb/nvm_prot_guard_test.sv
module nvm_prot_guard_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  flash_cfg, ee_cfg;
  logic        req_valid = 1'b0, req_ee = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [15:0] req_addr = '0;
  logic        viol_clr = 1'b0;
  logic        req_ok, req_blocked, viol_flag;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nvm_prot_guard uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .flash_cfg(flash_cfg), .ee_cfg(ee_cfg),
    .req_valid(req_valid), .req_ee(req_ee), .req_kind(req_kind),
    .req_addr(req_addr), .viol_clr(viol_clr), .req_ok(req_ok),
    .req_blocked(req_blocked), .viol_flag(viol_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d, input logic [7:0] exp, input string tag);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
    chk(tag, sel ? ee_cfg : flash_cfg, exp);
  endtask

  task automatic rq(input logic ee, input logic [1:0] k, input logic [15:0] a,
                    input logic exp_blk, input logic clr, input string tag);
    @(negedge clk); req_valid = 1'b1; req_ee = ee; req_kind = k; req_addr = a; viol_clr = clr;
    @(negedge clk); req_valid = 1'b0; viol_clr = 1'b0;
    chk(tag, {req_ok, req_blocked}, exp_blk ? 32'h1 : 32'h2);
  endtask

  task automatic clear_flag(input string tag);
    @(negedge clk); viol_clr = 1'b1;
    @(negedge clk); viol_clr = 1'b0;
    chk(tag, viol_flag, 0);
  endtask

  task automatic t_reset;
    chk("R1 flash cfg reset", flash_cfg, 8'hC8);
    chk("R1 ee cfg reset", ee_cfg, 8'h80);
    chk("R1 flag reset", viol_flag, 0);
    rq(0, 2'd0, 16'hFFFF, 0, 0, "R1 top byte open");
    rq(0, 2'd2, 16'h0000, 0, 0, "R1 flash block erase open");
    rq(1, 2'd2, 16'h0000, 0, 0, "R1 ee block erase open");
  endtask

  task automatic t_top;
    wr(0, 8'h98, 8'h98, "R2 enable top 4KB");
    rq(0, 2'd0, 16'hF000, 1, 0, "R2 F000 protected");
    chk("R10 flag set by block", viol_flag, 1);
    clear_flag("R10 flag cleared");
    rq(0, 2'd0, 16'hEFFF, 0, 0, "R2 EFFF free");
    wr(0, 8'hB8, 8'hB8, "R6 top grows to 16KB");
    rq(0, 2'd0, 16'hC000, 1, 0, "R2 C000 protected");
    rq(0, 2'd0, 16'hBFFF, 0, 0, "R2 BFFF free");
    wr(0, 8'hC8, 8'hB8, "R6 top cannot shrink or disable");
    rq(0, 2'd0, 16'hC000, 1, 0, "R6 C000 still protected");
  endtask

  task automatic t_base;
    wr(0, 8'hB2, 8'hB2, "R3 enable base 4KB");
    rq(0, 2'd0, 16'h8000, 1, 0, "R3 8000 protected");
    rq(0, 2'd0, 16'h8FFF, 1, 0, "R3 8FFF protected");
    rq(0, 2'd0, 16'h9000, 0, 0, "R3 9000 free");
    rq(0, 2'd0, 16'h7FFF, 0, 0, "R3 7FFF free");
    wr(0, 8'hB3, 8'hB3, "R6 base grows to 8KB");
    wr(0, 8'hC1, 8'hB3, "R8 all fields illegal held");
    rq(0, 2'd1, 16'hA1FF, 0, 0, "R9 sector A000 free");
    rq(0, 2'd1, 16'h9F00, 1, 0, "R9 sector 9E00 protected");
    rq(0, 2'd1, 16'hBE10, 0, 0, "R9 sector BE00 free");
    rq(0, 2'd2, 16'h1234, 1, 0, "R9 flash block erase blocked");
    rq(0, 2'd3, 16'h0000, 1, 0, "R9 kind 3 acts as block");
  endtask

  task automatic t_closed;
    wr(0, 8'h03, 8'h33, "R8 close applied size shrink held");
    rq(0, 2'd0, 16'h0100, 1, 0, "R4 0100 protected");
    rq(0, 2'd0, 16'h7FFF, 1, 0, "R4 7FFF protected");
    wr(0, 8'hFF, 8'h33, "R6 cannot reopen");
  endtask

  task automatic t_ee;
    wr(1, 8'h82, 8'h82, "R7 size while unlocked");
    rq(1, 2'd0, 16'h00FF, 0, 0, "R5 unlocked FF free");
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 8'h02;
    req_valid = 1'b1; req_ee = 1'b1; req_kind = 2'd0; req_addr = 16'h00A0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R11 same-cycle uses old setting", {req_ok, req_blocked}, 32'h2);
    chk("R11 write visible next cycle", ee_cfg, 8'h02);
    rq(1, 2'd0, 16'h00A0, 1, 0, "R5 A0 protected");
    rq(1, 2'd0, 16'h009F, 0, 0, "R5 9F free");
    rq(1, 2'd1, 16'h009F, 0, 0, "R9 ee sector 9E free");
    rq(1, 2'd1, 16'h00A1, 1, 0, "R9 ee sector A0 protected");
    rq(1, 2'd2, 16'h0000, 1, 0, "R9 ee block erase blocked");
    wr(1, 8'h81, 8'h02, "R7 unlock and shrink ignored");
    wr(1, 8'h07, 8'h07, "R7 grow to full");
    rq(1, 2'd0, 16'h0000, 1, 0, "R5 whole ee protected");
  endtask

  task automatic t_flag;
    clear_flag("R10 flag clear");
    rq(0, 2'd0, 16'h4000, 1, 1, "R10 block with clear");
    chk("R10 block wins over clear", viol_flag, 1);
    clear_flag("R10 flag clear again");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_top();
    t_base();
    t_closed();
    t_ee();
    t_flag();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
    end
    #1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule